// File: doc/BRIEF.md
# Configurable Serial Audio Input Deserializer

This block takes one serial audio data line together with a bit clock and a frame clock. It turns the bit stream into parallel sample words. Each word comes out with the channel index it belongs to and a one-cycle valid strobe. All logic runs on a single system clock. The incoming serial clocks are oversampled: the selected bit clock, frame clock and data line pass through a two-flop synchronizer, and the active bit-clock edge is found by comparing the synchronized level with the level one cycle earlier.

A 16-bit mode word sets the whole behaviour. It is held in a local register that reset loads with 0x3C00 and that `mode_load` overwrites. It chooses:
- square-wave or narrow-pulse frame sync;
- bit clock and frame clock polarity;
- data width and MSB delay;
- channel layout;
- the clock source: slave to one of several external clock pairs, or master with an internal clock pair at one of three rates.

When the mode word asks for a width and delay pair that does not fit in a slot, the block raises an error flag and narrows the width so that the data fits.

Capture is controlled by a three-state machine:
- **HUNT**: waiting for the first frame start.
- **GAP**: the current bit is outside a data word.
- **CAPTURE**: a word is being shifted in.

Its transitions are:
- *lock*: HUNT to GAP or CAPTURE on the first frame start.
- *word_begin*: GAP to CAPTURE at slot offset 0.
- *word_end*: CAPTURE to GAP on the last data bit, which emits the sample.
- *overrun*: CAPTURE to GAP when the offset jumps past the width after a resync.
- *restart*: any state to HUNT on a mode load.

Top module: `tdm_serial_rx`

## Requirements
- R1: After reset the mode register holds 0x3C00, and that mode gives no error and disabled clock outputs. Mode 0x3C00 means: stereo, 24-bit data, MSB delay 1, square-wave frame sync, both polarities negative, and slave to the port's own clock domain (source code 1111).
- R2: In stereo mode, frame bit 0 is the first bit at which the normalized frame clock is high. Channel 0 occupies slot 0 and channel 1 occupies slot 1. Each slot is 32 bits, and the MSB arrives at slot bit 1. Each word is emitted once, with the matching channel index.
- R3: Mode bits [7:6] select the width: 00 gives 24 bits, 01 gives 20, 10 gives 16, and 11 gives 16 with the error flag set. Slot bits beyond the width are ignored. The sample is placed at the top of the 24-bit output word, and the unused low bits are zero.
- R4: Mode bits [5:4] select the MSB delay within each slot: 00 gives 1 bit clock, 01 gives 12, 10 gives 16, and 11 gives 1 with the error flag set.
- R5: A delay of 12 with 24-bit width sets the error flag and captures 20 bits. A delay of 16 with any width other than 16 sets the error flag and captures 16 bits.
- R6: Mode bits [3:2] select the channel layout: 00 is stereo, 01 is 4-channel TDM, and 10 is 8-channel TDM. TDM layouts use 32-bit slots, channel n sits in slot n, and the emitted channel index is always below the channel count.
- R7: Layout code 11 is packed 4-channel TDM with 16-bit slots, 16-bit data and delay 1. Any other width or delay in this layout sets the error flag and is replaced by 16 bits with delay 1. The last channel's LSB falls on bit 0 of the following frame.
- R8: When mode bit 14 is 1, a one-bit-wide frame pulse marks the frame start. When it is 0, a 50% square wave does, and in stereo mode that square wave's opposite transition also realigns the counter to slot 1.
- R9: Mode bit 9 set to 0 samples data on the bit clock's rising edge, and set to 1 on its falling edge. Mode bit 8 set to 0 treats a low frame clock as the active (normalized high) phase, and set to 1 treats a high frame clock as active.
- R10: Mode bits [13:10] select the clock source. Codes 0 to NUM_DOMAINS-1 select an external clock pair. Code 1111 selects the port's own domain. Codes 1001, 1010 and 1011 select master mode. All other codes set the error flag and fall back to the own domain. Clock pairs that are not selected have no effect.
- R11: In master mode the internal bit clock has a half period of 16, 8 or 4 system clocks for codes 1001, 1010 and 1011. Its frame clock follows the configured layout and sync type, and data is captured from it exactly as in slave mode.
- R12: Mode bit 15 drives both clock output enables.
- R13: The valid strobe lasts one system clock per sample. It rises one cycle after the register that sees the sampling edge of the word's last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_load | input | 1 | Writes mode_data into the mode register and restarts capture |
| mode_data | input | 16 | New mode word |
| dom_bclk | input | NUM_DOMAINS | External bit clocks, one per clock domain |
| dom_fclk | input | NUM_DOMAINS | External frame clocks, one per clock domain |
| sdata | input | 1 | Serial audio data |
| bclk_out | output | 1 | Bit clock produced in master mode |
| bclk_oe | output | 1 | Output enable for bclk_out |
| fclk_out | output | 1 | Frame clock produced in master mode |
| fclk_oe | output | 1 | Output enable for fclk_out |
| cfg_err | output | 1 | The mode word holds an illegal combination |
| smp_word | output | 24 | Captured sample, left-justified |
| smp_chan | output | 3 | Channel index of smp_word |
| smp_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench drives slots with channel values whose bit patterns are all different, and fills every bit outside the data with ones. A wrong MSB position, slot index or zero-fill therefore shows up as a changed word rather than a shifted copy of the same value.

The same generator covers the different modes:
- Stereo, 4- and 8-channel TDM, and packed TDM separate the slot-length and channel-count logic.
- Delays 1, 12 and 16 separate the offset arithmetic.
- Pulse versus square frame sync, and inverted polarities, separate the edge and level choices.

Driving a clock pair that is not selected, and bit clocks generated internally at two rates, show that the source select and the rate divider act independently of the capture path.

// File: rtl/sai_pkg.sv
package sai_pkg;

    typedef enum logic [1:0] {
        FMT_STEREO = 2'd0,
        FMT_TDM4   = 2'd1,
        FMT_TDM8   = 2'd2,
        FMT_PACK4  = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_GAP     = 2'd1,
        ST_CAPTURE = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic       drive_clk;
        logic       pulse_sync;
        logic       bpol;
        logic       fpol;
        logic       master;
        logic [1:0] rate;
        logic [3:0] dom;
        logic [4:0] width;
        logic [4:0] delay;
        fmt_e       fmt;
        logic [2:0] slot_lg;
        logic [3:0] frame_lg;
    } cfg_t;

    localparam int WORD_W = 24;

endpackage

// File: rtl/sai_mode_decode.sv
module sai_mode_decode
    import sai_pkg::*;
#(
    parameter int NUM_DOMAINS = 9,
    parameter int OWN_DOMAIN  = 0
) (
    input  logic [15:0] mode,
    output cfg_t        cfg,
    output logic        err
);

    logic [3:0] src;
    assign src = mode[13:10];

    always_comb begin
        err            = 1'b0;
        cfg            = '0;
        cfg.drive_clk  = mode[15];
        cfg.pulse_sync = mode[14];
        cfg.bpol       = mode[9];
        cfg.fpol       = mode[8];
        cfg.dom        = 4'(OWN_DOMAIN);

        // clock source
        if (int'(src) < NUM_DOMAINS) begin
            cfg.dom = src;
        end else if (src == 4'b1001 || src == 4'b1010 || src == 4'b1011) begin
            cfg.master = 1'b1;
            cfg.rate   = src[1:0] - 2'd1;
        end else if (src != 4'b1111) begin
            err = 1'b1;
        end

        unique case (mode[7:6])
            2'b00: cfg.width = 5'd24;
            2'b01: cfg.width = 5'd20;
            2'b10: cfg.width = 5'd16;
            default: begin
                cfg.width = 5'd16;
                err       = 1'b1;
            end
        endcase

        unique case (mode[5:4])
            2'b00: cfg.delay = 5'd1;
            2'b01: cfg.delay = 5'd12;
            2'b10: cfg.delay = 5'd16;
            default: begin
                cfg.delay = 5'd1;
                err       = 1'b1;
            end
        endcase

        cfg.fmt = fmt_e'(mode[3:2]);

        // slot-fit legality
        if (cfg.delay == 5'd12 && cfg.width == 5'd24) begin
            cfg.width = 5'd20;
            err       = 1'b1;
        end
        if (cfg.delay == 5'd16 && cfg.width != 5'd16) begin
            cfg.width = 5'd16;
            err       = 1'b1;
        end
        if (cfg.fmt == FMT_PACK4 && (cfg.width != 5'd16 || cfg.delay != 5'd1)) begin
            cfg.width = 5'd16;
            cfg.delay = 5'd1;
            err       = 1'b1;
        end

        unique case (cfg.fmt)
            FMT_STEREO: begin cfg.slot_lg = 3'd5; cfg.frame_lg = 4'd6; end
            FMT_TDM4:   begin cfg.slot_lg = 3'd5; cfg.frame_lg = 4'd7; end
            FMT_TDM8:   begin cfg.slot_lg = 3'd5; cfg.frame_lg = 4'd8; end
            default:    begin cfg.slot_lg = 3'd4; cfg.frame_lg = 4'd6; end
        endcase
    end

endmodule

// File: rtl/sai_clk_gen.sv
module sai_clk_gen #(
    parameter int HALF_NORMAL = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] rate,
    input  logic       bpol,
    input  logic       fpol,
    input  logic       pulse,
    input  logic [3:0] frame_lg,
    output logic       bclk_o,
    output logic       fclk_o
);

    localparam int CW = $clog2(HALF_NORMAL) + 1;

    logic [CW-1:0] div;
    logic [CW-1:0] half;
    logic          ph;      // 0: launch phase, 1: sample phase
    logic [7:0]    mcnt;
    logic          fnorm;
    logic [7:0]    fmask;
    logic [7:0]    nm;
    logic [7:0]    half_frame;

    assign half       = CW'(HALF_NORMAL >> rate);
    assign fmask      = (8'd1 << frame_lg) - 8'd1;
    assign nm         = (mcnt + 8'd1) & fmask;
    assign half_frame = 8'd1 << (frame_lg - 4'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div   <= '0;
            ph    <= 1'b0;
            mcnt  <= 8'hFF;
            fnorm <= 1'b0;
        end else if (!en) begin
            div   <= '0;
            ph    <= 1'b0;
            mcnt  <= 8'hFF;
            fnorm <= 1'b0;
        end else if (div == half - CW'(1)) begin
            div <= '0;
            ph  <= ~ph;
            if (ph) begin
                mcnt  <= nm;
                fnorm <= pulse ? (nm == 8'd0) : (nm < half_frame);
            end
        end else begin
            div <= div + CW'(1);
        end
    end

    assign bclk_o = ph ^ bpol;
    assign fclk_o = fpol ? fnorm : ~fnorm;

    // R11: a bit-clock phase always lasts at least two system clocks
    assert_bclk_half_min_R11: assert property (
        @(posedge clk) disable iff (!rst_n || !en)
        !$stable(ph) |=> $stable(ph)
    );

endmodule

// File: rtl/sai_edge_front.sv
module sai_edge_front #(
    parameter int NUM_DOMAINS = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_DOMAINS-1:0] dom_bclk,
    input  logic [NUM_DOMAINS-1:0] dom_fclk,
    input  logic                   sdata,
    input  logic                   int_bclk,
    input  logic                   int_fclk,
    input  logic                   master,
    input  logic [3:0]             dom,
    input  logic                   bpol,
    input  logic                   fpol,
    output logic                   samp,
    output logic                   fnorm,
    output logic                   dbit
);

    logic       b_sel, f_sel;
    logic [2:0] s1, s2;
    logic       b_prev;

    always_comb begin
        b_sel = 1'b0;
        f_sel = 1'b0;
        for (int i = 0; i < NUM_DOMAINS; i++) begin
            if (int'(dom) == i) begin
                b_sel = dom_bclk[i];
                f_sel = dom_fclk[i];
            end
        end
        if (master) begin
            b_sel = int_bclk;
            f_sel = int_fclk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1     <= '0;
            s2     <= '0;
            b_prev <= 1'b0;
        end else begin
            s1     <= {b_sel, f_sel, sdata};
            s2     <= s1;
            b_prev <= s2[2];
        end
    end

    // sampling edge: rising for polarity 0, falling for polarity 1
    assign samp  = (s2[2] ^ bpol) & ~(b_prev ^ bpol);
    assign fnorm = fpol ? s2[1] : ~s2[1];
    assign dbit  = s2[0];

endmodule

// File: rtl/sai_deser_fsm.sv
module sai_deser_fsm
    import sai_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              samp,
    input  logic              fnorm,
    input  logic              dbit,
    input  cfg_t              cfg,
    output logic [WORD_W-1:0] word,
    output logic [2:0]        chan,
    output logic              valid
);

    rx_state_e   state, state_n;
    logic        fprev;
    logic [7:0]  cnt, cnt_n;
    logic [23:0] sh;
    logic        fstart, fhalf;
    logic [7:0]  fmask, p, slot;
    logic [4:0]  smask, off;
    logic        emit;
    logic [23:0] cap;
    logic [3:0]  nchan;

    assign fstart = fnorm & ~fprev;
    assign fhalf  = ~fnorm & fprev & ~cfg.pulse_sync & (cfg.fmt == FMT_STEREO);
    assign fmask  = (8'd1 << cfg.frame_lg) - 8'd1;
    assign smask  = (5'd1 << cfg.slot_lg) - 5'd1;
    assign nchan  = 4'd1 << (cfg.frame_lg - {1'b0, cfg.slot_lg});

    always_comb begin
        if (fstart)     cnt_n = 8'd0;
        else if (fhalf) cnt_n = 8'd32;
        else            cnt_n = (cnt + 8'd1) & fmask;
    end

    assign p    = (cnt_n - {3'b0, cfg.delay}) & fmask;
    assign off  = p[4:0] & smask;
    assign slot = p >> cfg.slot_lg;
    assign cap  = {sh[22:0], dbit} << (5'd24 - cfg.width);
    assign emit = (state == ST_CAPTURE) && samp && (off == cfg.width - 5'd1) && (off != 5'd0);

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_HUNT: begin
                if (samp && fstart)                  // lock
                    state_n = (off == 5'd0) ? ST_CAPTURE : ST_GAP;
            end
            ST_GAP: begin
                if (samp && off == 5'd0)             // word_begin
                    state_n = ST_CAPTURE;
            end
            ST_CAPTURE: begin
                if (samp) begin
                    if (off == 5'd0)                 // word_begin after resync
                        state_n = ST_CAPTURE;
                    else if (off >= cfg.width - 5'd1) // word_end / overrun
                        state_n = ST_GAP;
                end
            end
            default: state_n = ST_HUNT;
        endcase
        if (restart) state_n = ST_HUNT;              // restart
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_n;
    end

    // bit counter, frame-phase history and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fprev <= 1'b0;
            cnt   <= 8'd0;
            sh    <= '0;
        end else if (samp) begin
            fprev <= fnorm;
            cnt   <= cnt_n;
            if (off == 5'd0 && state_n == ST_CAPTURE)
                sh <= {23'b0, dbit};
            else if (state == ST_CAPTURE)
                sh <= {sh[22:0], dbit};
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            word  <= '0;
            chan  <= '0;
        end else begin
            valid <= emit && !restart;
            if (emit) begin
                word <= cap;
                chan <= slot[2:0];
            end
        end
    end

    assert_valid_single_R13: assert property (
        @(posedge clk) disable iff (!rst_n)
        valid |=> !valid
    );

    assert_chan_in_range_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        valid |-> ({1'b0, chan} < nchan)
    );

    assert_zero_fill_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        valid |-> ((word & ((24'd1 << (5'd24 - cfg.width)) - 24'd1)) == 24'd0)
    );

    assert_restart_hunt_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        restart |=> (state == ST_HUNT && !valid)
    );

endmodule

// File: rtl/tdm_serial_rx.sv
module tdm_serial_rx
    import sai_pkg::*;
#(
    parameter int          NUM_DOMAINS = 9,
    parameter int          OWN_DOMAIN  = 0,
    parameter int          HALF_NORMAL = 16,
    parameter logic [15:0] RESET_MODE  = 16'h3C00
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_load,
    input  logic [15:0]            mode_data,
    input  logic [NUM_DOMAINS-1:0] dom_bclk,
    input  logic [NUM_DOMAINS-1:0] dom_fclk,
    input  logic                   sdata,
    output logic                   bclk_out,
    output logic                   bclk_oe,
    output logic                   fclk_out,
    output logic                   fclk_oe,
    output logic                   cfg_err,
    output logic [WORD_W-1:0]      smp_word,
    output logic [2:0]             smp_chan,
    output logic                   smp_valid
);

    logic [15:0] mode_q;
    cfg_t        cfg;
    logic        int_b, int_f;
    logic        samp, fnorm, dbit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mode_q <= RESET_MODE;
        else if (mode_load) mode_q <= mode_data;
    end

    sai_mode_decode #(.NUM_DOMAINS(NUM_DOMAINS), .OWN_DOMAIN(OWN_DOMAIN)) u_dec (
        .mode (mode_q),
        .cfg  (cfg),
        .err  (cfg_err)
    );

    sai_clk_gen #(.HALF_NORMAL(HALF_NORMAL)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg.master),
        .rate     (cfg.rate),
        .bpol     (cfg.bpol),
        .fpol     (cfg.fpol),
        .pulse    (cfg.pulse_sync),
        .frame_lg (cfg.frame_lg),
        .bclk_o   (int_b),
        .fclk_o   (int_f)
    );

    sai_edge_front #(.NUM_DOMAINS(NUM_DOMAINS)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .dom_bclk (dom_bclk),
        .dom_fclk (dom_fclk),
        .sdata    (sdata),
        .int_bclk (int_b),
        .int_fclk (int_f),
        .master   (cfg.master),
        .dom      (cfg.dom),
        .bpol     (cfg.bpol),
        .fpol     (cfg.fpol),
        .samp     (samp),
        .fnorm    (fnorm),
        .dbit     (dbit)
    );

    sai_deser_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (mode_load),
        .samp    (samp),
        .fnorm   (fnorm),
        .dbit    (dbit),
        .cfg     (cfg),
        .word    (smp_word),
        .chan    (smp_chan),
        .valid   (smp_valid)
    );

    assign bclk_out = int_b;
    assign fclk_out = int_f;
    assign bclk_oe  = cfg.drive_clk;
    assign fclk_oe  = cfg.drive_clk;

    // R12: enables change only in the cycle after a mode load
    assert_oe_on_load_R12: assert property (
        @(posedge clk) disable iff (!rst_n)
        !mode_load |=> $stable(bclk_oe)
    );

endmodule

// File: tb/tdm_serial_rx_tb.sv
module tdm_serial_rx_tb_top;

    localparam int ND = 9;
    localparam int TH = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_load = 1'b0;
    logic [15:0]   mode_data = '0;
    logic [ND-1:0] dom_bclk, dom_fclk;
    logic          sdata = 1'b1;
    logic          bclk_out, bclk_oe, fclk_out, fclk_oe, cfg_err;
    logic [23:0]   smp_word;
    logic [2:0]    smp_chan;
    logic          smp_valid;

    always #10 clk = ~clk;

    tdm_serial_rx dut_i (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_data(mode_data),
        .dom_bclk(dom_bclk), .dom_fclk(dom_fclk), .sdata(sdata),
        .bclk_out(bclk_out), .bclk_oe(bclk_oe), .fclk_out(fclk_out), .fclk_oe(fclk_oe),
        .cfg_err(cfg_err), .smp_word(smp_word), .smp_chan(smp_chan), .smp_valid(smp_valid)
    );

    int checks = 0;
    int failures = 0;

    // stimulus state
    logic        bclk = 1'b1, fclk = 1'b1;
    int          tb_dom = 0;
    int          tb_nch = 2, tb_slot = 32, tb_w = 24, tb_dly = 1;
    logic        tb_bpol = 1'b0, tb_fpol = 1'b0, tb_pulse = 1'b0;
    logic [23:0] vals [8];
    logic        fb [256];
    int          flen = 64;

    always_comb begin
        for (int i = 0; i < ND; i++) begin
            dom_bclk[i] = (i == tb_dom) ? bclk : 1'b0;
            dom_fclk[i] = (i == tb_dom) ? fclk : 1'b0;
        end
    end

    // sample monitor
    logic [23:0] rec_word [64];
    logic [2:0]  rec_ch [64];
    int          nrec = 0;
    int          dbl = 0;
    logic        prev_v = 1'b0;

    always @(negedge clk) begin
        if (smp_valid) begin
            if (prev_v) dbl++;
            if (nrec < 64) begin
                rec_word[nrec] = smp_word;
                rec_ch[nrec]   = smp_chan;
            end
            nrec++;
        end
        prev_v = smp_valid;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] wmask(input int w);
        return ~((24'd1 << (24 - w)) - 24'd1);
    endfunction

    function automatic logic fnorm_of(input int i);
        return tb_pulse ? (i == 0) : (i < flen / 2);
    endfunction

    task automatic build_frame();
        flen = tb_nch * tb_slot;
        for (int i = 0; i < 256; i++) fb[i] = 1'b1;
        for (int ch = 0; ch < tb_nch; ch++)
            for (int k = 0; k < tb_w; k++)
                fb[(ch * tb_slot + tb_dly + k) % flen] = vals[ch][23 - k];
    endtask

    task automatic drive_bit(input logic d, input logic nrm);
        bclk  = tb_bpol;
        fclk  = tb_fpol ? nrm : ~nrm;
        sdata = d;
        repeat (TH) @(negedge clk);
        bclk = ~tb_bpol;
        repeat (TH) @(negedge clk);
    endtask

    task automatic load(input logic [15:0] m, input logic bp, input logic fp);
        tb_bpol = bp;
        tb_fpol = fp;
        bclk    = ~bp;
        fclk    = fp ? 1'b0 : 1'b1;
        repeat (4) @(negedge clk);
        mode_data = m;
        mode_load = 1'b1;
        @(negedge clk);
        mode_load = 1'b0;
        repeat (4) @(negedge clk);
        nrec = 0;
    endtask

    task automatic send_frames(input int n);
        build_frame();
        drive_bit(1'b1, 1'b0);
        drive_bit(1'b1, 1'b0);
        for (int f = 0; f < n; f++)
            for (int i = 0; i < flen; i++)
                drive_bit(fb[i], fnorm_of(i));
        drive_bit(1'b1, 1'b0);
        drive_bit(1'b1, 1'b0);
        repeat (20) @(negedge clk);
    endtask

    task automatic expect_frame(input string tag);
        for (int ch = 0; ch < tb_nch; ch++) begin
            if (ch < nrec) begin
                chk(rec_ch[ch] == 3'(ch), {tag, " chan"}, int'(rec_ch[ch]), ch);
                chk(rec_word[ch] == (vals[ch] & wmask(tb_w)), {tag, " word"},
                    int'(rec_word[ch]), int'(vals[ch] & wmask(tb_w)));
            end else begin
                chk(1'b0, {tag, " missing sample"}, nrec, ch + 1);
            end
        end
    endtask

    task automatic set_vals();
        vals[0] = 24'hA5C3E1; vals[1] = 24'h5A3C1E; vals[2] = 24'h9D6B2F; vals[3] = 24'h3E7A85;
        vals[4] = 24'hC1F04D; vals[5] = 24'h7B28E6; vals[6] = 24'h2F95C3; vals[7] = 24'hE4D1B7;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_default();
        chk(cfg_err == 1'b0, "R1 reset err", cfg_err, 0);
        chk(bclk_oe == 1'b0 && fclk_oe == 1'b0, "R1 reset oe", bclk_oe, 0);
        chk(smp_valid == 1'b0, "R1 reset valid", smp_valid, 0);
        tb_nch = 2; tb_slot = 32; tb_w = 24; tb_dly = 1; tb_pulse = 0; tb_dom = 0;
        nrec = 0;
        send_frames(2);
        expect_frame("R1 R2 default stereo");
        chk(nrec == 4, "R2 sample count", nrec, 4);
    endtask

    task automatic t_widths();
        load(16'h3C40, 0, 0); tb_w = 20; send_frames(2);
        chk(cfg_err == 1'b0, "R3 w20 err", cfg_err, 0);
        expect_frame("R3 width20");
        load(16'h3C80, 0, 0); tb_w = 16; send_frames(2);
        expect_frame("R3 width16");
    endtask

    task automatic t_delays();
        load(16'h3C50, 0, 0); tb_w = 20; tb_dly = 12; send_frames(2);
        chk(cfg_err == 1'b0, "R4 d12 err", cfg_err, 0);
        expect_frame("R4 delay12");
        load(16'h3CA0, 0, 0); tb_w = 16; tb_dly = 16; send_frames(2);
        expect_frame("R4 delay16");
    endtask

    task automatic t_illegal();
        load(16'h3C10, 0, 0); tb_w = 20; tb_dly = 12; send_frames(2);
        chk(cfg_err == 1'b1, "R5 d12w24 err", cfg_err, 1);
        expect_frame("R5 d12 forced20");
        load(16'h3C20, 0, 0); tb_w = 16; tb_dly = 16; send_frames(2);
        chk(cfg_err == 1'b1, "R5 d16w24 err", cfg_err, 1);
        expect_frame("R5 d16 forced16");
        load(16'h3CC0, 0, 0);
        chk(cfg_err == 1'b1, "R3 width code 11 err", cfg_err, 1);
        load(16'h3C30, 0, 0);
        chk(cfg_err == 1'b1, "R4 delay code 11 err", cfg_err, 1);
        tb_w = 24; tb_dly = 1;
    endtask

    task automatic t_tdm();
        load(16'h3C04, 0, 0); tb_nch = 4; send_frames(2);
        expect_frame("R6 tdm4");
        load(16'h3C08, 0, 0); tb_nch = 8; send_frames(2);
        expect_frame("R6 tdm8");
    endtask

    task automatic t_packed();
        load(16'h3C8C, 0, 0); tb_nch = 4; tb_slot = 16; tb_w = 16; tb_dly = 1;
        send_frames(2);
        chk(cfg_err == 1'b0, "R7 packed err", cfg_err, 0);
        expect_frame("R7 packed4");
        load(16'h3C0C, 0, 0);
        chk(cfg_err == 1'b1, "R7 packed w24 err", cfg_err, 1);
        send_frames(2);
        expect_frame("R7 packed forced");
        tb_slot = 32; tb_nch = 2; tb_w = 24;
    endtask

    task automatic t_pulse();
        load(16'h7C00, 0, 0); tb_pulse = 1; send_frames(2);
        expect_frame("R8 pulse sync");
        tb_pulse = 0;
    endtask

    task automatic t_polarity();
        load(16'h3F00, 1, 1); send_frames(2);
        expect_frame("R9 inverted pol");
        load(16'h3C00, 0, 0);
    endtask

    task automatic t_domain();
        load(16'h0C00, 0, 0); tb_dom = 3; send_frames(2);
        expect_frame("R10 domain3");
        load(16'h0C00, 0, 0); tb_dom = 5; send_frames(2);
        chk(nrec == 0, "R10 unselected domain ignored", nrec, 0);
        load(16'h3000, 0, 0);
        chk(cfg_err == 1'b1, "R10 reserved source err", cfg_err, 1);
        tb_dom = 0;
    endtask

    task automatic measure_half(input int expv, input string tag);
        int n = 0;
        logic pb;
        pb = bclk_out;
        while (bclk_out == pb) @(negedge clk);
        pb = bclk_out;
        while (bclk_out == pb) begin
            @(negedge clk);
            n++;
        end
        chk(n == expv, tag, n, expv);
    endtask

    task automatic t_master();
        logic pb, pn, nrm;
        int   i, launches;
        bit   started;
        load(16'hAC00, 0, 0);
        chk(bclk_oe == 1'b1 && fclk_oe == 1'b1, "R12 oe on", bclk_oe, 1);
        measure_half(4, "R11 quad half period");
        load(16'hA400, 0, 0);
        measure_half(16, "R11 normal half period");
        tb_nch = 2; tb_slot = 32; tb_w = 24; tb_dly = 1;
        build_frame();
        nrec = 0;
        pb = bclk_out; pn = 1'b0; i = 0; launches = 0; started = 0;
        while (launches < 2 * flen + 2) begin
            @(negedge clk);
            if (pb == 1'b1 && bclk_out == 1'b0) begin
                nrm = ~fclk_out;
                if (nrm && !pn) begin
                    i = 0;
                    started = 1;
                end else begin
                    i++;
                end
                pn = nrm;
                if (started) begin
                    sdata = fb[i % flen];
                    launches++;
                end
            end
            pb = bclk_out;
        end
        repeat (60) @(negedge clk);
        expect_frame("R11 master capture");
        load(16'h3C00, 0, 0);
        chk(bclk_oe == 1'b0, "R12 oe off", bclk_oe, 0);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        set_vals();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset_default();
        t_widths();
        t_delays();
        t_illegal();
        t_tdm();
        t_packed();
        t_pulse();
        t_polarity();
        t_domain();
        t_master();
        chk(dbl == 0, "R13 valid single cycle", dbl, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule